// File: doc/BRIEF.md
# Uncorrectable Error First-Record Log with Pending Queue

This block holds the capture state for the first uncorrectable error a function has seen: a pointer to the status bit of that error, a four-word header image, a four-word prefix image and a flag that says whether the prefix image is meaningful. The uncorrectable status register itself lives outside the block. Its current value is fed in on `stat_value`. The block hands back a vector of bits that the owner of that register must set again.

An error record arrives as a one-cycle request that carries a one-hot status, a header, a prefix and two flags. Multiple-header recording may be switched on. If it is on and the status bit named by the pointer is still set, the record waits in a small queue instead of overwriting the log. A full queue drops the record and pulses an overflow output. When software writes the status register, the owner pulses `stat_wr` with the new value. Clearing the pointed-to bit then either empties the log or refills it from the oldest queued record. Leaving that bit set either restores any queued bits software cleared or throws the queue away, depending on whether multiple-header recording is on.

Top module: `errlog_hdr_queue`

## Requirements
- R1: A record whose status does not have exactly one bit set is rejected. `rec_reject` pulses one cycle after the request, and the pointer, logs, prefix flag and queue stay unchanged.
- R2: When a record loads the log, `first_ptr` becomes the bit index of its set status bit. Bit 0 is index 0.
- R3: If `mhr_active` is 1 and `stat_value[first_ptr]` is 1, a valid record is queued and the log is left unchanged. If the queue already holds QDEPTH records, the record is lost, the queue is unchanged and `ovf_pulse` is high for exactly one cycle.
- R4: Header word i is taken from `rec_hdr[32i+31:32i]` and stored in `hdr_log[32i+31:32i]` with its four bytes reversed (byte 0 ends up in bits 31:24). When `rec_hdr_valid` is 0, `hdr_log` is zero.
- R5: `pfx_log` takes the byte-reversed prefix words (same layout as R4) and `pfx_logged` becomes 1 only when `rec_pfx_present` and `e2e_pfx_supported` are both 1. Otherwise `pfx_log` is zero and `pfx_logged` is 0.
- R6: A status write with `stat_value[first_ptr]`=0 clears `first_ptr`, `pfx_logged`, `hdr_log` and `pfx_log` to zero when `mhr_active` is 0 or the queue is empty.
- R7: A status write with `stat_value[first_ptr]`=0, `mhr_active`=1 and a non-empty queue pops the oldest record into the log, as R2, R4 and R5 describe. For one cycle it also drives `restat_vec` to the OR of the statuses of every record that was queued before the pop, the popped one included.
- R8: A status write with `stat_value[first_ptr]`=1 and `mhr_active`=1 drives `restat_vec`, for one cycle, to the OR of all queued statuses. Log and queue are unchanged. At every other time `restat_vec` is zero.
- R9: A status write with `stat_value[first_ptr]`=1 and `mhr_active`=0 empties the queue. The log is left unchanged.
- R10: `mhr_capable` is 1 exactly when QDEPTH > 0, and `mhr_active` equals `mhr_enable` AND `mhr_capable`.
- R11: Queued records leave the queue strictly in arrival order.
- R12: After reset the pointer, flag, logs, queue level, `restat_vec`, `ovf_pulse` and `rec_reject` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rec_valid | input | 1 | Error record request, one cycle |
| rec_status | input | 32 | Status bit of the record (one-hot) |
| rec_hdr | input | 128 | Header words, word i at bits 32i+31:32i |
| rec_pfx | input | 128 | Prefix words, same layout |
| rec_hdr_valid | input | 1 | Header words are meaningful |
| rec_pfx_present | input | 1 | Record carries a prefix |
| e2e_pfx_supported | input | 1 | End-to-end prefixes supported by the function |
| mhr_enable | input | 1 | Software enable for multiple-header recording |
| stat_wr | input | 1 | Software wrote the uncorrectable status register |
| stat_value | input | 32 | Current value of the uncorrectable status register |
| mhr_capable | output | 1 | Multiple-header recording available |
| mhr_active | output | 1 | Multiple-header recording in force |
| first_ptr | output | 5 | First-error bit index |
| pfx_logged | output | 1 | Prefix log holds a prefix |
| hdr_log | output | 128 | Header log image |
| pfx_log | output | 128 | Prefix log image |
| restat_vec | output | 32 | Status bits to set again, valid one cycle |
| ovf_pulse | output | 1 | Queue overflow, one cycle |
| rec_reject | output | 1 | Malformed record dropped, one cycle |
| q_level | output | 3 | Number of queued records |

## Verification
The assertions rely on two things about the inputs: a record request and a status write never fall in the same cycle, and `stat_value` is stable while either one is asserted. The bench issues each request and each write in its own cycle and holds `stat_value` with it. Its random stimulus chooses, per operation, whether the pointed-to status bit is set, so that every branch of the queue and write handling is reached. It also mixes in malformed statuses, and it toggles `mhr_enable` between operations, never at the same time as one.

// File: rtl/errlog_pkg.sv
package errlog_pkg;

  localparam int EL_STAT_W    = 32;
  localparam int EL_WORD_W    = 32;
  localparam int EL_LOG_WORDS = 4;
  localparam int EL_LOG_W     = EL_WORD_W * EL_LOG_WORDS;
  localparam int EL_PTR_W     = $clog2(EL_STAT_W);
  localparam int EL_BYTES     = EL_WORD_W / 8;

  typedef struct packed {
    logic [EL_STAT_W-1:0] status;
    logic [EL_LOG_W-1:0]  hdr;
    logic [EL_LOG_W-1:0]  pfx;
    logic                 hdr_ok;
    logic                 pfx_ok;
  } el_rec_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CLEAR,
    ACT_REFILL,
    ACT_RESTORE,
    ACT_DROP
  } el_act_e;

  function automatic logic el_single(input logic [EL_STAT_W-1:0] s);
    return (s != '0) && ((s & (s - 1'b1)) == '0);
  endfunction

  function automatic logic [EL_PTR_W-1:0] el_low_index(input logic [EL_STAT_W-1:0] s);
    logic [EL_PTR_W-1:0] idx;
    idx = '0;
    for (int i = EL_STAT_W - 1; i >= 0; i--) begin
      if (s[i]) idx = EL_PTR_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [EL_LOG_W-1:0] el_swap_words(input logic [EL_LOG_W-1:0] w);
    logic [EL_LOG_W-1:0] o;
    for (int k = 0; k < EL_LOG_WORDS; k++) begin
      for (int b = 0; b < EL_BYTES; b++) begin
        o[k*EL_WORD_W + (EL_BYTES-1-b)*8 +: 8] = w[k*EL_WORD_W + b*8 +: 8];
      end
    end
    return o;
  endfunction

endpackage

// File: rtl/errlog_fifo.sv
module errlog_fifo
  import errlog_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 push,
  input  logic                 pop,
  input  logic                 flush,
  input  el_rec_t              din,
  output el_rec_t              head,
  output logic [CW-1:0]        count,
  output logic [EL_STAT_W-1:0] stat_union
);

  el_rec_t       slot [DEPTH];
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      for (int i = 0; i < DEPTH; i++) slot[i] <= '0;
    end else if (flush) begin
      cnt <= '0;
    end else if (pop && cnt != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) slot[i] <= slot[i+1];
      cnt <= cnt - 1'b1;
    end else if (push && cnt != CW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt) slot[i] <= din;
      end
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    stat_union = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i) < cnt) stat_union = stat_union | slot[i].status;
    end
  end

  assign head  = slot[0];
  assign count = cnt;

endmodule

// File: rtl/errlog_image.sv
module errlog_image
  import errlog_pkg::*;
(
  input  el_rec_t             src,
  input  logic                e2e_ok,
  output logic [EL_PTR_W-1:0] ptr,
  output logic [EL_LOG_W-1:0] hdr_img,
  output logic [EL_LOG_W-1:0] pfx_img,
  output logic                pfx_flag
);

  assign ptr      = el_low_index(src.status);
  assign hdr_img  = src.hdr_ok ? el_swap_words(src.hdr) : '0;
  assign pfx_flag = src.pfx_ok & e2e_ok;
  assign pfx_img  = pfx_flag ? el_swap_words(src.pfx) : '0;

endmodule

// File: rtl/errlog_hdr_queue.sv
module errlog_hdr_queue
  import errlog_pkg::*;
#(
  parameter int QDEPTH = 4,
  localparam int CW = (QDEPTH > 0) ? $clog2(QDEPTH + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rec_valid,
  input  logic [EL_STAT_W-1:0] rec_status,
  input  logic [EL_LOG_W-1:0]  rec_hdr,
  input  logic [EL_LOG_W-1:0]  rec_pfx,
  input  logic                 rec_hdr_valid,
  input  logic                 rec_pfx_present,
  input  logic                 e2e_pfx_supported,
  input  logic                 mhr_enable,
  input  logic                 stat_wr,
  input  logic [EL_STAT_W-1:0] stat_value,
  output logic                 mhr_capable,
  output logic                 mhr_active,
  output logic [EL_PTR_W-1:0]  first_ptr,
  output logic                 pfx_logged,
  output logic [EL_LOG_W-1:0]  hdr_log,
  output logic [EL_LOG_W-1:0]  pfx_log,
  output logic [EL_STAT_W-1:0] restat_vec,
  output logic                 ovf_pulse,
  output logic                 rec_reject,
  output logic [CW-1:0]        q_level
);

  localparam logic HAS_QUEUE = (QDEPTH > 0);

  el_rec_t              rec_in, q_head, load_src;
  logic [EL_STAT_W-1:0] q_union;
  logic                 q_full, q_empty;
  logic                 fep_pending;
  logic                 ev_bad, ev_queue, ev_push, ev_overflow, ev_load, ev_refill;
  el_act_e              wr_act;
  logic [EL_PTR_W-1:0]  img_ptr;
  logic [EL_LOG_W-1:0]  img_hdr, img_pfx;
  logic                 img_pfx_flag;

  assign mhr_capable = HAS_QUEUE;
  assign mhr_active  = mhr_enable & HAS_QUEUE;

  assign rec_in = '{status: rec_status, hdr: rec_hdr, pfx: rec_pfx,
                    hdr_ok: rec_hdr_valid, pfx_ok: rec_pfx_present};

  assign fep_pending = stat_value[first_ptr];
  assign q_full      = (q_level == CW'(QDEPTH));
  assign q_empty     = (q_level == '0);

  assign ev_bad      = rec_valid & ~el_single(rec_status);
  assign ev_queue    = rec_valid & ~ev_bad & mhr_active & fep_pending;
  assign ev_push     = ev_queue & ~q_full;
  assign ev_overflow = ev_queue & q_full;
  assign ev_load     = rec_valid & ~ev_bad & ~ev_queue;

  always_comb begin
    wr_act = ACT_NONE;
    if (stat_wr) begin
      if (!fep_pending) wr_act = (mhr_active && !q_empty) ? ACT_REFILL : ACT_CLEAR;
      else              wr_act = mhr_active ? ACT_RESTORE : ACT_DROP;
    end
  end

  assign ev_refill = (wr_act == ACT_REFILL);
  assign load_src  = ev_refill ? q_head : rec_in;

  generate
    if (QDEPTH > 0) begin : g_queue
      errlog_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (ev_push),
        .pop        (ev_refill),
        .flush      (wr_act == ACT_DROP),
        .din        (rec_in),
        .head       (q_head),
        .count      (q_level),
        .stat_union (q_union)
      );
    end else begin : g_no_queue
      assign q_head  = '0;
      assign q_level = '0;
      assign q_union = '0;
    end
  endgenerate

  errlog_image u_image (
    .src      (load_src),
    .e2e_ok   (e2e_pfx_supported),
    .ptr      (img_ptr),
    .hdr_img  (img_hdr),
    .pfx_img  (img_pfx),
    .pfx_flag (img_pfx_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_ptr  <= '0;
      pfx_logged <= 1'b0;
      hdr_log    <= '0;
      pfx_log    <= '0;
    end else if (ev_load || ev_refill) begin
      first_ptr  <= img_ptr;
      pfx_logged <= img_pfx_flag;
      hdr_log    <= img_hdr;
      pfx_log    <= img_pfx;
    end else if (wr_act == ACT_CLEAR) begin
      first_ptr  <= '0;
      pfx_logged <= 1'b0;
      hdr_log    <= '0;
      pfx_log    <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      restat_vec <= '0;
      ovf_pulse  <= 1'b0;
      rec_reject <= 1'b0;
    end else begin
      restat_vec <= (ev_refill || wr_act == ACT_RESTORE) ? q_union : '0;
      ovf_pulse  <= ev_overflow;
      rec_reject <= ev_bad;
    end
  end

endmodule

// File: rtl/errlog_chk.sv
module errlog_chk
  import errlog_pkg::*;
#(
  parameter int QDEPTH = 4,
  localparam int CW = (QDEPTH > 0) ? $clog2(QDEPTH + 1) : 1
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rec_valid,
  input logic [EL_STAT_W-1:0] rec_status,
  input logic                 stat_wr,
  input logic [EL_STAT_W-1:0] stat_value,
  input logic                 mhr_capable,
  input logic                 mhr_active,
  input logic [EL_PTR_W-1:0]  first_ptr,
  input logic                 pfx_logged,
  input logic [EL_LOG_W-1:0]  hdr_log,
  input logic [EL_LOG_W-1:0]  pfx_log,
  input logic [EL_STAT_W-1:0] restat_vec,
  input logic                 ovf_pulse,
  input logic                 rec_reject,
  input logic [CW-1:0]        q_level
);

  // Input contract that the queueing decision (R3) depends on
  assert_req_wr_apart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && stat_wr));

  assert_reject_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && $countones(rec_status) != 1)
      |=> (rec_reject && $stable(first_ptr) && $stable(hdr_log) && $stable(q_level)));

  assert_ovf_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ($past(rec_valid) && $past(q_level) == CW'(QDEPTH) && q_level == CW'(QDEPTH)));

  assert_qbound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    q_level <= CW'(QDEPTH));

  assert_pfx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pfx_logged |-> (pfx_log == '0));

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_value[first_ptr] && q_level == '0)
      |=> (first_ptr == '0 && !pfx_logged && hdr_log == '0 && pfx_log == '0));

  assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !stat_value[first_ptr] && mhr_active && q_level != '0)
      |=> (q_level == $past(q_level) - 1'b1 && restat_vec != '0));

  assert_restat_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (restat_vec != '0) |-> $past(stat_wr));

  assert_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && stat_value[first_ptr] && !mhr_active) |=> (q_level == '0 && $stable(hdr_log)));

  assert_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mhr_active |-> mhr_capable);

endmodule

bind errlog_hdr_queue errlog_chk #(.QDEPTH(QDEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rec_valid   (rec_valid),
  .rec_status  (rec_status),
  .stat_wr     (stat_wr),
  .stat_value  (stat_value),
  .mhr_capable (mhr_capable),
  .mhr_active  (mhr_active),
  .first_ptr   (first_ptr),
  .pfx_logged  (pfx_logged),
  .hdr_log     (hdr_log),
  .pfx_log     (pfx_log),
  .restat_vec  (restat_vec),
  .ovf_pulse   (ovf_pulse),
  .rec_reject  (rec_reject),
  .q_level     (q_level)
);

// File: tb/errlog_hdr_queue_tb.sv
module errlog_hdr_queue_tb;

  localparam int QD = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rec_valid = 1'b0;
  logic [31:0]  rec_status = '0;
  logic [127:0] rec_hdr = '0, rec_pfx = '0;
  logic         rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
  logic         e2e_pfx_supported = 1'b0, mhr_enable = 1'b0;
  logic         stat_wr = 1'b0;
  logic [31:0]  stat_value = '0;
  logic         mhr_capable, mhr_active, pfx_logged, ovf_pulse, rec_reject;
  logic [4:0]   first_ptr;
  logic [127:0] hdr_log, pfx_log;
  logic [31:0]  restat_vec;
  logic [2:0]   q_level;

  always #5 clk = ~clk;

  errlog_hdr_queue #(.QDEPTH(QD)) u_dut (.*);

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  logic [4:0]   m_ptr;
  logic         m_pf;
  logic [127:0] m_hdr, m_pfx;
  logic [31:0]  mq_st [QD];
  logic [127:0] mq_h [QD], mq_p [QD];
  logic         mq_hv [QD], mq_pp [QD];
  int           m_cnt;
  logic [31:0]  e_restat;
  logic         e_ovf, e_rej;

  function automatic logic [127:0] ref_swap(input logic [127:0] x);
    logic [127:0] y;
    for (int w = 0; w < 4; w++) begin
      logic [31:0] v;
      v = x[w*32 +: 32];
      y[w*32 +: 32] = {v[7:0], v[15:8], v[23:16], v[31:24]};
    end
    return y;
  endfunction

  function automatic logic [4:0] ref_index(input logic [31:0] s);
    for (int i = 0; i < 32; i++) if (s[i]) return 5'(i);
    return 5'd0;
  endfunction

  function automatic bit ref_single(input logic [31:0] s);
    int n = 0;
    for (int i = 0; i < 32; i++) if (s[i]) n++;
    return n == 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ref_load(input logic [31:0] st, input logic [127:0] h, input logic [127:0] p,
                          input logic hv, input logic pp);
    m_ptr = ref_index(st);
    m_hdr = hv ? ref_swap(h) : '0;
    m_pf  = pp & e2e_pfx_supported;
    m_pfx = m_pf ? ref_swap(p) : '0;
  endtask

  task automatic compare_all(input string t_ptr, input string t_log, input string t_pfx, input string t_q);
    chk(first_ptr == m_ptr, t_ptr, 128'(first_ptr), 128'(m_ptr));
    chk(hdr_log == m_hdr, t_log, hdr_log, m_hdr);
    chk(pfx_log == m_pfx && pfx_logged == m_pf, t_pfx, pfx_log, m_pfx);
    chk(int'(q_level) == m_cnt, t_q, 128'(q_level), 128'(m_cnt));
    chk(ovf_pulse == e_ovf, "R3", 128'(ovf_pulse), 128'(e_ovf));
    chk(rec_reject == e_rej, "R1", 128'(rec_reject), 128'(e_rej));
    chk(restat_vec == e_restat, "R8", 128'(restat_vec), 128'(e_restat));
  endtask

  task automatic do_rec(input logic [31:0] st, input logic [127:0] h, input logic [127:0] p,
                        input logic hv, input logic pp, input logic [31:0] sv);
    e_ovf = 0; e_rej = 0; e_restat = '0;
    if (!ref_single(st)) e_rej = 1;
    else if (mhr_enable && sv[m_ptr]) begin
      if (m_cnt == QD) e_ovf = 1;
      else begin
        mq_st[m_cnt] = st; mq_h[m_cnt] = h; mq_p[m_cnt] = p;
        mq_hv[m_cnt] = hv; mq_pp[m_cnt] = pp; m_cnt++;
      end
    end else ref_load(st, h, p, hv, pp);
    rec_valid = 1; rec_status = st; rec_hdr = h; rec_pfx = p;
    rec_hdr_valid = hv; rec_pfx_present = pp; stat_value = sv;
    @(negedge clk);
    rec_valid = 0;
    compare_all("R2", "R4", "R5", "R3");
  endtask

  task automatic do_wr(input logic [31:0] sv);
    string tg;
    logic [31:0] u = '0;
    e_ovf = 0; e_rej = 0; e_restat = '0;
    for (int i = 0; i < m_cnt; i++) u = u | mq_st[i];
    if (!sv[m_ptr]) begin
      if (!mhr_enable || m_cnt == 0) begin
        tg = "R6"; m_ptr = 0; m_pf = 0; m_hdr = '0; m_pfx = '0;
      end else begin
        tg = "R7"; e_restat = u;
        ref_load(mq_st[0], mq_h[0], mq_p[0], mq_hv[0], mq_pp[0]);
        for (int i = 0; i < QD - 1; i++) begin
          mq_st[i] = mq_st[i+1]; mq_h[i] = mq_h[i+1]; mq_p[i] = mq_p[i+1];
          mq_hv[i] = mq_hv[i+1]; mq_pp[i] = mq_pp[i+1];
        end
        m_cnt--;
      end
    end else if (mhr_enable) begin
      tg = "R8"; e_restat = u;
    end else begin
      tg = "R9"; m_cnt = 0;
    end
    stat_wr = 1; stat_value = sv;
    @(negedge clk);
    stat_wr = 0;
    compare_all(tg, tg, tg, tg);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] s, sv;
    void'($urandom(32'd4711));
    m_ptr = 0; m_pf = 0; m_hdr = '0; m_pfx = '0; m_cnt = 0;
    e_restat = '0; e_ovf = 0; e_rej = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    compare_all("R12", "R12", "R12", "R12");
    chk(mhr_capable == 1'b1, "R10", 128'(mhr_capable), 128'd1);
    chk(mhr_active == 1'b0, "R10", 128'(mhr_active), 128'd0);
    mhr_enable = 1; #1;
    chk(mhr_active == 1'b1, "R10", 128'(mhr_active), 128'd1);
    mhr_enable = 0;
    @(negedge clk);

    // directed load with prefix
    e2e_pfx_supported = 1;
    do_rec(32'h20, {96'h0, 32'h11223344}, {96'h0, 32'hA1B2C3D4}, 1, 1, 32'h0);
    chk(hdr_log[31:0] == 32'h44332211, "R4", 128'(hdr_log[31:0]), 128'h44332211);
    chk(first_ptr == 5'd5, "R2", 128'(first_ptr), 128'd5);
    chk(pfx_logged == 1'b1, "R5", 128'(pfx_logged), 128'd1);
    // malformed status
    do_rec(32'h6, '1, '1, 1, 1, 32'h0);
    do_rec(32'h0, '1, '1, 1, 1, 32'h0);
    // fill queue then overflow
    mhr_enable = 1;
    for (int i = 1; i <= QD + 1; i++)
      do_rec(32'h1 << (i + 8), {96'h0, 32'(i)}, '0, 1, 0, 32'h20);
    chk(ovf_pulse == 1'b1, "R3", 128'(ovf_pulse), 128'd1);
    @(negedge clk);
    chk(ovf_pulse == 1'b0, "R3", 128'(ovf_pulse), 128'd0);
    // restore while first bit pending
    do_wr(32'h20);
    chk(restat_vec == 32'h1E00, "R8", 128'(restat_vec), 128'h1E00);
    // pop in order
    do_wr(32'h0);
    chk(hdr_log[31:0] == 32'h01000000, "R11", 128'(hdr_log[31:0]), 128'h01000000);
    chk(restat_vec == 32'h1E00, "R7", 128'(restat_vec), 128'h1E00);
    do_wr(32'h0);
    chk(hdr_log[31:0] == 32'h02000000, "R11", 128'(hdr_log[31:0]), 128'h02000000);
    // drop with recording off
    mhr_enable = 0;
    do_wr(32'hFFFF_FFFF);
    chk(q_level == 3'd0, "R9", 128'(q_level), 128'd0);
    do_wr(32'h0);
    chk(hdr_log == '0 && first_ptr == 0, "R6", hdr_log, 128'd0);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(0, 15) == 0) mhr_enable = ~mhr_enable;
      if ($urandom_range(0, 31) == 0) e2e_pfx_supported = ~e2e_pfx_supported;
      sv = $urandom;
      if ($urandom_range(0, 1) != 0) sv[m_ptr] = 1'b1; else sv[m_ptr] = 1'b0;
      if ($urandom_range(0, 2) != 0) begin
        s = 32'h1 << $urandom_range(0, 31);
        if ($urandom_range(0, 9) == 0) s = $urandom;
        do_rec(s, {$urandom, $urandom, $urandom, $urandom}, {$urandom, $urandom, $urandom, $urandom},
               1'($urandom), 1'($urandom), sv);
      end else begin
        do_wr(sv);
      end
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule